// File: doc/BRIEF.md
# Receive Descriptor Ring Selector

This block decides which of up to four receive buffer-descriptor rings takes a frame that has just landed, complete and good, in the receive FIFO. It also keeps the current descriptor address of every ring. When the receive write side reports a finished frame, the block takes the length from the status FIFO. It then looks at the rings in fixed order, ring 0 (A) first and ring 3 (D) last. It passes over any ring that is disabled or whose current descriptor is flagged full. It stops at the first ring whose programmed maximum frame size is at least the frame length.

The result is a ring index and that ring's current descriptor address. Both are presented with a valid flag and held until the downstream consumer acknowledges them. The acknowledge marks the end of the frame, and it moves the chosen ring to its next descriptor: either 0x10 further on, or back to the ring's base pointer when that descriptor is marked as the last one. If no ring can take the frame, the block gives a single-cycle no-buffer pulse and leaves every pointer alone.

An initialization request copies the four base pointers into the current-descriptor registers and then raises a done status. Frames that arrive before that status is set, or while receive DMA is disabled, are held pending.

Top module: `rx_ring_sel`

## Requirements
- R1: Out of reset, sel_valid_o, no_buf_o and init_done_o are all 0.
- R2: An init_req_i sampled high clears init_done_o on the next cycle. It then loads every ring's current descriptor from base_ptr_i. init_done_o reads 1 after the fourth rising edge following the edge that sampled the request (one load cycle per ring).
- R3: A frame_rdy_i pulse seen before init_done_o is 1 is held pending. Its selection starts once initialization has completed, and sel_valid_o is never raised while init_done_o is 0.
- R4: The selected ring is the lowest-index ring with ring_en_i[i]=1, ring_full_i[i]=0 and maximum at least frame_len_i. The maximum is ring_max_i[i*LEN_W +: LEN_W]. sel_ring_o encodes ring A as 0 through ring D as 3.
- R5: A disabled ring or a ring flagged full is skipped even when it is large enough. A frame length equal to a ring's maximum fits that ring.
- R6: If no ring qualifies, no_buf_o is high for exactly one cycle, sel_valid_o stays 0 and no ring pointer changes.
- R7: For a frame accepted while the block is idle, the result (sel_valid_o or no_buf_o) first appears after the fifth rising edge following the edge that sampled frame_rdy_i, and not before.
- R8: While sel_valid_o is 1 and sel_ack_i is 0, sel_valid_o, sel_ring_o and sel_addr_o stay unchanged, even if the ring inputs change.
- R9: sel_ack_i while valid clears sel_valid_o on the next cycle and advances only the chosen ring's pointer by 0x10 (base_ptr_i ring i is bits [i*ADDR_W +: ADDR_W]).
- R10: If ring_last_i[i] is 1 for the chosen ring when it is acknowledged, that ring's pointer reloads its base pointer instead of advancing.
- R11: While dma_en_i is 0, no selection runs. A frame pulse received then is held and is processed once dma_en_i is set: its result appears after the fifth rising edge following the first edge at which dma_en_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dma_en_i | input | 1 | Global receive DMA enable |
| frame_rdy_i | input | 1 | Good frame complete in receive FIFO (pulse) |
| frame_len_i | input | LEN_W | Frame length from status FIFO |
| ring_en_i | input | N | Per-ring enable |
| ring_full_i | input | N | Per-ring current descriptor full flag |
| ring_last_i | input | N | Per-ring current descriptor is last (wrap) |
| ring_max_i | input | N*LEN_W | Per-ring maximum frame size, packed by ring |
| base_ptr_i | input | N*ADDR_W | Per-ring base pointer, packed by ring |
| init_req_i | input | 1 | Load current descriptors from base pointers |
| sel_ack_i | input | 1 | Consumer accepts result, end of frame |
| sel_valid_o | output | 1 | Selection result valid |
| sel_ring_o | output | IDX_W | Selected ring index |
| sel_addr_o | output | ADDR_W | Current descriptor address of selected ring |
| no_buf_o | output | 1 | One-cycle pulse: no ring can take the frame |
| init_done_o | output | 1 | Descriptor initialization complete |

## Verification
On every cycle the assertions check four things. The no-buffer indication is a single-cycle pulse and never coincides with a valid result. A held result stays frozen until it is acknowledged, and an acknowledge clears it. An initialization request drops the done status. The bench scenarios show what depends on chosen input patterns and on the bench's own model of the pointers. That covers the order of the first-fit search, skipping of full and disabled rings, the equal-length boundary, the exact five-cycle latency, the 0x10 advance against base reload on wrap, and frames deferred by initialization or by a disabled DMA enable.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} sel_st_e;
  localparam int unsigned SEL_LAT = 5;
  localparam int unsigned STG_W = $clog2(SEL_LAT);
endpackage

// File: rtl/rx_ring_fit.sv
module rx_ring_fit #(
  parameter int unsigned N     = 4,
  parameter int unsigned LEN_W = 16
) (
  input  logic [LEN_W-1:0]   len_i,
  input  logic [N-1:0]       en_i,
  input  logic [N-1:0]       full_i,
  input  logic [N*LEN_W-1:0] max_i,
  output logic [N-1:0]       cand_o
);
  for (genvar g = 0; g < N; g++) begin : g_fit
    assign cand_o[g] = en_i[g] & ~full_i[g] & (max_i[g*LEN_W +: LEN_W] >= len_i);
  end
endmodule

// File: rtl/rx_ring_pick.sv
module rx_ring_pick #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     cand_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rx_ring_ptr.sv
module rx_ring_ptr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STRIDE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              wrap_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_o <= '0;
    else if (load_i) ptr_o <= base_i;
    else if (adv_i) ptr_o <= wrap_i ? base_i : ptr_o + ADDR_W'(STRIDE);
  end
endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
#(
  parameter int unsigned N      = 4,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dma_en_i,
  input  logic              frame_rdy_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  input  logic              init_req_i,
  input  logic              sel_ack_i,
  input  logic [N-1:0]      cand_i,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] idx_ptr_i,
  output logic [LEN_W-1:0]  len_o,
  output logic [N-1:0]      cand_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [N-1:0]      load_o,
  output logic              adv_o,
  output logic              valid_o,
  output logic              no_buf_o,
  output logic              init_done_o,
  output logic [ADDR_W-1:0] addr_o
);
  sel_st_e          st_q;
  logic [STG_W-1:0] stg_q;
  logic             hit_q;
  logic             pend_q;
  logic [LEN_W-1:0] pend_len_q;
  logic             busy_q;
  logic [IDX_W-1:0] icnt_q;
  logic             go;

  assign go = (st_q == ST_IDLE) && init_done_o && !busy_q && dma_en_i
              && (frame_rdy_i || pend_q);
  assign adv_o = (st_q == ST_HOLD) && sel_ack_i;

  always_comb begin
    load_o = '0;
    if (busy_q) load_o[icnt_q] = 1'b1;
  end

  // init sequencer: one ring per cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      icnt_q      <= '0;
      init_done_o <= 1'b0;
    end else if (init_req_i) begin
      busy_q      <= 1'b1;
      icnt_q      <= '0;
      init_done_o <= 1'b0;
    end else if (busy_q) begin
      icnt_q <= icnt_q + 1'b1;
      if (icnt_q == IDX_W'(N - 1)) begin
        busy_q      <= 1'b0;
        init_done_o <= 1'b1;
      end
    end
  end

  // deferred frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_len_q <= '0;
    end else if (go) begin
      pend_q <= 1'b0;
    end else if (frame_rdy_i) begin
      pend_q     <= 1'b1;
      pend_len_q <= frame_len_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      stg_q    <= '0;
      len_o    <= '0;
      cand_o   <= '0;
      hit_q    <= 1'b0;
      idx_o    <= '0;
      addr_o   <= '0;
      valid_o  <= 1'b0;
      no_buf_o <= 1'b0;
    end else begin
      no_buf_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (go) begin
            len_o <= pend_q ? pend_len_q : frame_len_i;
            stg_q <= '0;
            st_q  <= ST_RUN;
          end
        end
        ST_RUN: begin
          stg_q <= stg_q + 1'b1;
          case (stg_q)
            STG_W'(0): cand_o <= cand_i;
            STG_W'(1): begin
              hit_q <= hit_i;
              idx_o <= idx_i;
            end
            STG_W'(2): addr_o <= idx_ptr_i;
            default: ;
          endcase
          if (stg_q == STG_W'(SEL_LAT - 1)) begin
            if (hit_q) begin
              valid_o <= 1'b1;
              st_q    <= ST_HOLD;
            end else begin
              no_buf_o <= 1'b1;
              st_q     <= ST_IDLE;
            end
          end
        end
        ST_HOLD: begin
          if (sel_ack_i) begin
            valid_o <= 1'b0;
            st_q    <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_sel.sv
module rx_ring_sel #(
  parameter int unsigned N      = 4,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STRIDE = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dma_en_i,
  input  logic                frame_rdy_i,
  input  logic [LEN_W-1:0]    frame_len_i,
  input  logic [N-1:0]        ring_en_i,
  input  logic [N-1:0]        ring_full_i,
  input  logic [N-1:0]        ring_last_i,
  input  logic [N*LEN_W-1:0]  ring_max_i,
  input  logic [N*ADDR_W-1:0] base_ptr_i,
  input  logic                init_req_i,
  input  logic                sel_ack_i,
  output logic                sel_valid_o,
  output logic [IDX_W-1:0]    sel_ring_o,
  output logic [ADDR_W-1:0]   sel_addr_o,
  output logic                no_buf_o,
  output logic                init_done_o
);
  logic [LEN_W-1:0]  len_q;
  logic [N-1:0]      cand, cand_q, load;
  logic              hit, adv;
  logic [IDX_W-1:0]  pick_idx;
  logic [ADDR_W-1:0] ptr [N];
  logic [ADDR_W-1:0] idx_ptr;

  rx_ring_fit #(.N(N), .LEN_W(LEN_W)) u_fit (
    .len_i(len_q), .en_i(ring_en_i), .full_i(ring_full_i),
    .max_i(ring_max_i), .cand_o(cand)
  );

  rx_ring_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .cand_i(cand_q), .hit_o(hit), .idx_o(pick_idx)
  );

  for (genvar g = 0; g < N; g++) begin : g_ring
    rx_ring_ptr #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_ptr (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load[g]),
      .adv_i(adv && (sel_ring_o == IDX_W'(g))),
      .wrap_i(ring_last_i[g]),
      .base_i(base_ptr_i[g*ADDR_W +: ADDR_W]),
      .ptr_o(ptr[g])
    );
  end

  always_comb begin
    idx_ptr = '0;
    for (int i = 0; i < N; i++)
      if (sel_ring_o == IDX_W'(i)) idx_ptr = ptr[i];
  end

  rx_ring_ctrl #(.N(N), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .dma_en_i(dma_en_i),
    .frame_rdy_i(frame_rdy_i), .frame_len_i(frame_len_i),
    .init_req_i(init_req_i), .sel_ack_i(sel_ack_i),
    .cand_i(cand), .hit_i(hit), .idx_i(pick_idx), .idx_ptr_i(idx_ptr),
    .len_o(len_q), .cand_o(cand_q), .idx_o(sel_ring_o), .load_o(load),
    .adv_o(adv), .valid_o(sel_valid_o), .no_buf_o(no_buf_o),
    .init_done_o(init_done_o), .addr_o(sel_addr_o)
  );
endmodule

// File: rtl/rx_ring_sel_chk.sv
module rx_ring_sel_chk #(
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              init_req_i,
  input logic              sel_ack_i,
  input logic              sel_valid_o,
  input logic [IDX_W-1:0]  sel_ring_o,
  input logic [ADDR_W-1:0] sel_addr_o,
  input logic              no_buf_o,
  input logic              init_done_o
);
  assert_nobuf_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_buf_o |=> !no_buf_o);

  assert_nobuf_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(no_buf_o && sel_valid_o));

  assert_hold_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_valid_o && !sel_ack_i) |=> (sel_valid_o && $stable(sel_ring_o) && $stable(sel_addr_o)));

  assert_ack_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_valid_o && sel_ack_i) |=> !sel_valid_o);

  assert_init_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_req_i |=> !init_done_o);
endmodule

bind rx_ring_sel rx_ring_sel_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .init_req_i(init_req_i), .sel_ack_i(sel_ack_i),
  .sel_valid_o(sel_valid_o), .sel_ring_o(sel_ring_o), .sel_addr_o(sel_addr_o),
  .no_buf_o(no_buf_o), .init_done_o(init_done_o)
);

// File: tb/rx_ring_sel_bench.sv
module rx_ring_sel_bench;
  localparam int N = 4;
  localparam int LEN_W = 16;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dma_en = 1'b1, frame_rdy = 1'b0, init_req = 1'b0, ack = 1'b0;
  logic [LEN_W-1:0] frame_len = '0;
  logic [N-1:0] ring_en = '1, ring_full = '0, ring_last = '0;
  logic [N*LEN_W-1:0] ring_max = {16'd2048, 16'd1024, 16'd256, 16'd64};
  logic [N*ADDR_W-1:0] base_ptr;
  logic valid, no_buf, init_done;
  logic [1:0] ring;
  logic [ADDR_W-1:0] addr;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [ADDR_W-1:0] exp_ptr [N];

  always #5 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_base
    assign base_ptr[g*ADDR_W +: ADDR_W] = 32'h1000_0000 + 32'(g) * 32'h100;
  end

  rx_ring_sel u_rx_ring_sel (
    .clk_i(clk), .rst_ni(rst_ni), .dma_en_i(dma_en), .frame_rdy_i(frame_rdy),
    .frame_len_i(frame_len), .ring_en_i(ring_en), .ring_full_i(ring_full),
    .ring_last_i(ring_last), .ring_max_i(ring_max), .base_ptr_i(base_ptr),
    .init_req_i(init_req), .sel_ack_i(ack), .sel_valid_o(valid),
    .sel_ring_o(ring), .sel_addr_o(addr), .no_buf_o(no_buf), .init_done_o(init_done)
  );

  function automatic logic [ADDR_W-1:0] base_of(int r);
    return 32'h1000_0000 + 32'(r) * 32'h100;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic pulse_frame(logic [LEN_W-1:0] len);
    @(negedge clk); frame_rdy = 1'b1; frame_len = len;
    @(negedge clk); frame_rdy = 1'b0;
  endtask

  // hit: expect ring r; !hit: expect no-buffer pulse
  task automatic run_frame(logic [LEN_W-1:0] len, bit hit, int r, string tag);
    pulse_frame(len);
    repeat (4) @(negedge clk);
    check(!valid && !no_buf, {tag, " R7 early"}, {valid, no_buf}, 0);
    @(negedge clk);
    if (hit) begin
      check(valid && !no_buf, {tag, " R7 valid"}, {valid, no_buf}, 2'b10);
      check(ring == 2'(r), {tag, " R4 ring"}, ring, r);
      check(addr == exp_ptr[r], {tag, " R9 addr"}, addr, exp_ptr[r]);
    end else begin
      check(no_buf && !valid, {tag, " R6 nobuf"}, {valid, no_buf}, 2'b01);
      @(negedge clk);
      check(!no_buf && !valid, {tag, " R6 pulse"}, {valid, no_buf}, 0);
    end
  endtask

  task automatic do_ack(int r, bit wrap);
    @(negedge clk); ack = 1'b1; ring_last[r] = wrap;
    @(negedge clk); ack = 1'b0; ring_last = '0;
    exp_ptr[r] = wrap ? base_of(r) : exp_ptr[r] + 32'h10;
    check(!valid, "R9 ack clears", valid, 0);
  endtask

  task automatic t_reset();
    check(!valid && !no_buf && !init_done, "R1 reset", {valid, no_buf, init_done}, 0);
  endtask

  task automatic t_init();
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
    check(!init_done, "R2 done low", init_done, 0);
    repeat (3) @(negedge clk);
    check(!init_done, "R2 done early", init_done, 0);
    @(negedge clk);
    check(init_done, "R2 done", init_done, 1);
    for (int i = 0; i < N; i++) exp_ptr[i] = base_of(i);
    run_frame(16'd10, 1, 0, "init A");
    do_ack(0, 0);
  endtask

  task automatic t_first_fit();
    run_frame(16'd100, 1, 1, "fit B");
    do_ack(1, 0);
    run_frame(16'd64, 1, 0, "R5 equal A");
    do_ack(0, 0);
    run_frame(16'd1500, 1, 3, "fit D");
    do_ack(3, 0);
    run_frame(16'd256, 1, 1, "R5 equal B");
    do_ack(1, 0);
  endtask

  task automatic t_skip();
    ring_full = 4'b0001;
    run_frame(16'd10, 1, 1, "R5 full A");
    do_ack(1, 0);
    ring_en = 4'b1101;
    run_frame(16'd10, 1, 2, "R5 dis B");
    do_ack(2, 0);
    ring_full = '0; ring_en = '1;
  endtask

  task automatic t_nobuf();
    run_frame(16'd3000, 0, 0, "big");
    ring_en = 4'b0110; ring_full = 4'b0110;
    run_frame(16'd10, 0, 0, "all skip");
    ring_en = '1; ring_full = '0;
    for (int i = 0; i < N; i++) begin
      ring_en = 4'b0001 << i;
      run_frame(16'd10, 1, i, "R6 ptr kept");
      do_ack(i, 0);
    end
    ring_en = '1;
  endtask

  task automatic t_hold();
    logic [ADDR_W-1:0] a;
    run_frame(16'd500, 1, 2, "hold");
    a = addr;
    ring_full = '1; ring_en = '0;
    repeat (4) @(negedge clk);
    check(valid && ring == 2'd2 && addr == a, "R8 held", addr, a);
    ring_full = '0; ring_en = '1;
    do_ack(2, 0);
  endtask

  task automatic t_wrap();
    run_frame(16'd700, 1, 2, "wrap pre");
    do_ack(2, 1);
    run_frame(16'd700, 1, 2, "R10 wrap");
    check(addr == base_of(2), "R10 base", addr, base_of(2));
    do_ack(2, 0);
  endtask

  task automatic t_pend_init();
    bit seen = 0, bad = 0;
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0; frame_rdy = 1'b1; frame_len = 16'd100;
    @(negedge clk); frame_rdy = 1'b0;
    for (int i = 0; i < N; i++) exp_ptr[i] = base_of(i);
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (valid && !init_done) bad = 1;
      if (valid) seen = 1;
    end
    check(!bad, "R3 no early", bad, 0);
    check(seen, "R3 pending ran", seen, 1);
    check(ring == 2'd1 && addr == base_of(1), "R3 ring", addr, base_of(1));
    do_ack(1, 0);
  endtask

  task automatic t_dma_off();
    bit any = 0;
    @(negedge clk); dma_en = 1'b0;
    pulse_frame(16'd10);
    repeat (10) begin
      @(negedge clk);
      if (valid || no_buf) any = 1;
    end
    check(!any, "R11 idle", any, 0);
    dma_en = 1'b1;
    repeat (5) @(negedge clk);
    check(!valid, "R11 early", valid, 0);
    @(negedge clk);
    check(valid && ring == 2'd0 && addr == exp_ptr[0], "R11 run", addr, exp_ptr[0]);
    do_ack(0, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    for (int i = 0; i < N; i++) exp_ptr[i] = '0;
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_init();
    t_first_fit();
    t_skip();
    t_nobuf();
    t_hold();
    t_wrap();
    t_pend_init();
    t_dma_off();
    repeat (3) @(negedge clk);
    summary();
  end
endmodule